// File: doc/BRIEF.md
# Tick Timer with Compare and Capture

This block is a 32-bit up-counter that advances once for each cycle of a slow tick enable while it is running. Two compare channels watch the counter. Each compare channel raises an event flag when the counter steps onto its programmed value, and it drives an output pin with a selectable action. One capture channel stores the counter value when a chosen edge appears on an asynchronous input.

Software controls the block through simple one-cycle write strobes: start/stop commands, a direct counter load, a control word, compare values, interrupt enables and a write-one-to-clear mask for the flags. The flags and their enables combine into a single interrupt line. No bus decoding and no clock-domain crossing are included, apart from the synchroniser on the capture input.

Top module: `tick_timer_cc`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the following are all zero: count, running, flags, cap_value, cmp_out and irq. Both compare values are also zero.
- R2: A command write with cmd_data bit 0 (start) sets running on the next edge, and bit 1 (stop) clears it. If both bits are set, stop wins. The count advances by one only on edges where it is running and tick is high.
- R3: When the count steps from 0xFFFFFFFF to 0, flags bit 0 (overflow) is set on that same edge.
- R4: A counter write loads cnt_wdata on the next edge and overrides an increment in that cycle. The loaded value never produces a compare event.
- R5: An enabled compare channel sets its flag on the edge where an increment makes the count equal to its value. Channel 0 uses flags bit 1 and channel 1 uses flags bit 2. Nothing happens while the counter is stopped.
- R6: On a match, pin action 0 drives cmp_out low, action 1 drives it high and action 3 toggles it. Actions 5 to 7 leave the pin unchanged.
- R7: Pin action 2 drives cmp_out high for exactly one cycle after a match and keeps it low otherwise.
- R8: With pin action 4, cmp_out mirrors that channel's flag bit, including after the flag is cleared.
- R9: cap_in passes through two synchroniser flops before edge detection. Edge select 0 captures on rising edges, 1 on falling edges, 2 on both and 3 on none. A capture stores the count into cap_value and sets flags bit 3, three edges after cap_in changes.
- R10: Flags are sticky until cleared by writing a 1 to the matching bit of flag_clr. A new event in the same cycle wins over the clear.
- R11: irq is high exactly when any flag bit and the matching ien bit are both set. The enable mask is loaded by ien_wr.
- R12: In the control word, bit 0 enables compare 0, bit 1 enables compare 1 and bit 2 enables capture. Bits 5:3 hold the pin action for channel 0, bits 8:6 the pin action for channel 1, and bits 10:9 the capture edge select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable pulse |
| cmd_wr | input | 1 | Command strobe |
| cmd_data | input | 2 | Bit 0 start, bit 1 stop |
| cnt_wr | input | 1 | Direct counter load strobe |
| cnt_wdata | input | 32 | Counter load value |
| ctrl_wr | input | 1 | Control word strobe |
| ctrl_wdata | input | 11 | Control word value |
| cmp_wr | input | 2 | Per-channel compare value strobe |
| cmp_wdata | input | 32 | Compare value |
| ien_wr | input | 1 | Interrupt enable strobe |
| ien_wdata | input | 4 | Interrupt enable mask |
| flag_clr | input | 4 | Write-one-to-clear flag mask |
| cap_in | input | 1 | Asynchronous capture input |
| count | output | 32 | Counter value |
| running | output | 1 | Counter running status |
| flags | output | 4 | Event flags |
| cap_value | output | 32 | Last captured count |
| cmp_out | output | 2 | Compare output pins |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest event to reach from the ports is the wrap from all-ones to zero, because counting there would take about four billion ticks. The bench therefore loads the counter just below the wrap and ticks across it. Known capture values need a stopped counter, so the count is loaded, the edge on cap_in is applied, and the bench waits out the synchroniser delay. A set and a clear of the same flag in the same cycle, and pin-action changes in the middle of a sequence, are reached in a long random phase. That phase uses small compare values and counter loads so that matches happen often, and a cycle-accurate model is compared on every clock.

// File: rtl/tmr_pkg.sv
// Shared constants and encodings for the tick timer.
// Assumes exactly two compare channels; the control word layout depends on it.
package tmr_pkg;
    localparam int NCMP     = 2;
    localparam int NFLAG    = NCMP + 2;
    localparam int ACT_W    = 3;
    localparam int EDGE_W   = 2;
    localparam int ACT_LSB0 = NCMP + 1;
    localparam int EDGE_LSB = ACT_LSB0 + NCMP * ACT_W;
    localparam int CTRL_W   = EDGE_LSB + EDGE_W;
    localparam int FLG_OVF  = 0;
    localparam int FLG_CAP  = NCMP + 1;

    typedef enum logic [ACT_W-1:0] {
        ACT_LOW    = 3'd0,
        ACT_HIGH   = 3'd1,
        ACT_PULSE  = 3'd2,
        ACT_TOGGLE = 3'd3,
        ACT_FOLLOW = 3'd4
    } cmp_act_e;

    typedef enum logic [EDGE_W-1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_NONE = 2'd3
    } cap_edge_e;
endpackage

// File: rtl/tmr_counter.sv
// Counter core: holds the run state and the count value.
// Assumes the start and stop strobes are already qualified by the command write.
// The next value and the wrap event are exported so that the compare logic can
// detect a match on the edge where the count changes.
module tmr_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic          stop,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] count,
    output logic          running,
    output logic          adv,
    output logic [CW-1:0] next_val,
    output logic          wrap
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    assign adv      = run_q & tick & ~wr_en;
    assign next_val = cnt_q + ONE;
    assign wrap     = adv & (&cnt_q);
    assign count    = cnt_q;
    assign running  = run_q;

    // Run state: stop takes priority over start.
    always_ff @(posedge clk) begin
        if (!rst_n)     run_q <= 1'b0;
        else if (stop)  run_q <= 1'b0;
        else if (start) run_q <= 1'b1;
    end

    // Count value: a direct load beats an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (wr_en) cnt_q <= wr_data;
        else if (adv)   cnt_q <= next_val;
    end

    p_stop_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !running);
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == $past(wr_data)));
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(running && tick)) |=> $stable(count));
endmodule

// File: rtl/tmr_compare.sv
// One compare channel: holds the compare value, detects a match and drives the pin.
// Assumes adv/next_val describe the increment that happens on the coming edge.
// flag_now is this channel's registered flag, which the follow action mirrors.
module tmr_compare
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACT_W-1:0] act,
    input  logic             adv,
    input  logic [CW-1:0]    next_val,
    input  logic             val_wr,
    input  logic [CW-1:0]    val_wdata,
    input  logic             flag_now,
    output logic             match,
    output logic             pin
);
    logic [CW-1:0] val_q;
    logic          pin_q;
    cmp_act_e      act_e;

    assign act_e = cmp_act_e'(act);
    assign match = en & adv & (next_val == val_q);
    assign pin   = (act_e == ACT_FOLLOW) ? flag_now : pin_q;

    // Compare value register.
    always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= '0;
        else if (val_wr) val_q <= val_wdata;
    end

    // Pin state: applies the action on a match and ends a pulse after one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (match) begin
            case (act_e)
                ACT_LOW:    pin_q <= 1'b0;
                ACT_HIGH:   pin_q <= 1'b1;
                ACT_PULSE:  pin_q <= 1'b1;
                ACT_TOGGLE: pin_q <= ~pin_q;
                default:    pin_q <= pin_q;
            endcase
        end else if (act_e == ACT_PULSE) begin
            pin_q <= 1'b0;
        end
    end

    p_pulse_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && act_e == ACT_PULSE) |=> pin_q);
    p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (match && act_e == ACT_TOGGLE) |=> (pin_q != $past(pin_q)));
    p_match_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> adv);
endmodule

// File: rtl/tmr_capture.sv
// Capture channel: synchronises cap_in, detects the selected edge and stores the count.
// Assumes cap_in is asynchronous; two flops resolve metastability before edge detection.
module tmr_capture
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_in,
    input  logic              en,
    input  logic [EDGE_W-1:0] edge_sel,
    input  logic [CW-1:0]     count,
    output logic              evt,
    output logic [CW-1:0]     value
);
    logic      s1_q, s2_q, s3_q;
    logic      hit;
    cap_edge_e sel_e;

    assign sel_e = cap_edge_e'(edge_sel);

    // Synchroniser pair plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) {s1_q, s2_q, s3_q} <= 3'b000;
        else        {s1_q, s2_q, s3_q} <= {cap_in, s1_q, s2_q};
    end

    // Edge selection.
    always_comb begin
        case (sel_e)
            EDGE_RISE: hit = s2_q & ~s3_q;
            EDGE_FALL: hit = ~s2_q & s3_q;
            EDGE_BOTH: hit = s2_q ^ s3_q;
            default:   hit = 1'b0;
        endcase
    end

    assign evt = en & hit;

    // Captured value register.
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (evt) value <= count;
    end

    p_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (value == $past(count)));
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(value));
endmodule

// File: rtl/tick_timer_cc.sv
// Tick timer top: counter, two compare channels, one capture channel, the flags
// and the interrupt. Assumes all configuration arrives as one-cycle write strobes
// in the clk domain.
module tick_timer_cc
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_wr,
    input  logic [1:0]        cmd_data,
    input  logic              cnt_wr,
    input  logic [CW-1:0]     cnt_wdata,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [NCMP-1:0]   cmp_wr,
    input  logic [CW-1:0]     cmp_wdata,
    input  logic              ien_wr,
    input  logic [NFLAG-1:0]  ien_wdata,
    input  logic [NFLAG-1:0]  flag_clr,
    input  logic              cap_in,
    output logic [CW-1:0]     count,
    output logic              running,
    output logic [NFLAG-1:0]  flags,
    output logic [CW-1:0]     cap_value,
    output logic [NCMP-1:0]   cmp_out,
    output logic              irq
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [NFLAG-1:0]  ien_q;
    logic [NFLAG-1:0]  flags_q;
    logic [NFLAG-1:0]  set_v;
    logic [NCMP-1:0]   match;
    logic              adv, wrap, cap_evt;
    logic [CW-1:0]     next_val;

    // Control word and interrupt enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ien_q  <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_wdata;
            if (ien_wr)  ien_q  <= ien_wdata;
        end
    end

    tmr_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start(cmd_wr & cmd_data[0]), .stop(cmd_wr & cmd_data[1]),
        .wr_en(cnt_wr), .wr_data(cnt_wdata),
        .count(count), .running(running),
        .adv(adv), .next_val(next_val), .wrap(wrap)
    );

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        tmr_compare #(.CW(CW)) u_cmp (
            .clk(clk), .rst_n(rst_n),
            .en(ctrl_q[i]),
            .act(ctrl_q[ACT_LSB0 + ACT_W*i +: ACT_W]),
            .adv(adv), .next_val(next_val),
            .val_wr(cmp_wr[i]), .val_wdata(cmp_wdata),
            .flag_now(flags_q[i+1]),
            .match(match[i]), .pin(cmp_out[i])
        );
    end

    tmr_capture #(.CW(CW)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in),
        .en(ctrl_q[NCMP]), .edge_sel(ctrl_q[EDGE_LSB +: EDGE_W]),
        .count(count), .evt(cap_evt), .value(cap_value)
    );

    assign set_v = {cap_evt, match, wrap};

    // Sticky flags: new events win over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | set_v;
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & ien_q);

    p_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flags[FLG_OVF]);
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));
    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !irq);
    p_capture_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> flags[FLG_CAP]);
endmodule

// File: tb/sim_tick_timer_cc.sv
module sim_tick_timer_cc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 0, cmd_wr = 0, cnt_wr = 0, ctrl_wr = 0, ien_wr = 0, cap_in = 0;
    logic [1:0]  cmd_data = 0, cmp_wr = 0;
    logic [31:0] cnt_wdata = 0, cmp_wdata = 0;
    logic [10:0] ctrl_wdata = 0;
    logic [3:0]  ien_wdata = 0, flag_clr = 0;
    logic [31:0] count, cap_value;
    logic        running, irq;
    logic [3:0]  flags;
    logic [1:0]  cmp_out;

    int n_chk = 0, n_bad = 0;
    bit model_on = 0;

    always #2.5 clk = ~clk;

    tick_timer_cc u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .flag_clr(flag_clr), .cap_in(cap_in), .count(count), .running(running),
        .flags(flags), .cap_value(cap_value), .cmp_out(cmp_out), .irq(irq)
    );

    // Behavioural reference model.
    logic [31:0] m_cnt, m_cap, m_nxt;
    logic [31:0] m_cmp [2];
    logic        m_run, m_adv, m_hit, m_s2, m_s3;
    logic [3:0]  m_flags, m_ien, m_set;
    logic [10:0] m_ctrl;
    logic [1:0]  m_pin;
    logic        hist[$];
    int          act;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cap = 0; m_run = 0; m_flags = 0; m_ien = 0; m_ctrl = 0; m_pin = 0;
            m_cmp[0] = 0; m_cmp[1] = 0;
            hist = '{1'b0, 1'b0, 1'b0};
        end else begin
            m_adv = m_run && tick && !cnt_wr;
            m_nxt = m_cnt + 1;
            m_set = 0;
            if (m_adv && m_cnt == 32'hFFFF_FFFF) m_set[0] = 1;
            for (int ch = 0; ch < 2; ch++) begin
                act = int'(m_ctrl[3 + 3*ch +: 3]);
                if (m_ctrl[ch] && m_adv && m_nxt == m_cmp[ch]) begin
                    m_set[ch+1] = 1;
                    if (act == 0) m_pin[ch] = 0;
                    else if (act == 1 || act == 2) m_pin[ch] = 1;
                    else if (act == 3) m_pin[ch] = ~m_pin[ch];
                end else if (act == 2) m_pin[ch] = 0;
            end
            m_s2 = hist[1]; m_s3 = hist[2];
            case (m_ctrl[10:9])
                2'd0: m_hit = m_s2 && !m_s3;
                2'd1: m_hit = !m_s2 && m_s3;
                2'd2: m_hit = m_s2 != m_s3;
                default: m_hit = 0;
            endcase
            if (m_ctrl[2] && m_hit) begin m_cap = m_cnt; m_set[3] = 1; end
            m_flags = (m_flags & ~flag_clr) | m_set;
            if (cnt_wr) m_cnt = cnt_wdata; else if (m_adv) m_cnt = m_nxt;
            if (cmd_wr && cmd_data[1]) m_run = 0; else if (cmd_wr && cmd_data[0]) m_run = 1;
            if (ctrl_wr) m_ctrl = ctrl_wdata;
            if (ien_wr) m_ien = ien_wdata;
            if (cmp_wr[0]) m_cmp[0] = cmp_wdata;
            if (cmp_wr[1]) m_cmp[1] = cmp_wdata;
            hist.push_front(cap_in);
            void'(hist.pop_back());
        end
    end

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
        end
    endtask

    function automatic logic [1:0] m_out();
        logic [1:0] r;
        for (int ch = 0; ch < 2; ch++)
            r[ch] = (m_ctrl[3 + 3*ch +: 3] == 3'd4) ? m_flags[ch+1] : m_pin[ch];
        return r;
    endfunction

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk("R4", "count", count, m_cnt);
            chk("R2", "running", 32'(running), 32'(m_run));
            chk("R10", "flags", 32'(flags), 32'(m_flags));
            chk("R9", "cap_value", cap_value, m_cap);
            chk("R6", "cmp_out", 32'(cmp_out), 32'(m_out()));
            chk("R11", "irq", 32'(irq), 32'(|(m_flags & m_ien)));
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask
    task automatic w_cmd(logic [1:0] d);
        cmd_wr = 1; cmd_data = d; cyc(); cmd_wr = 0; cmd_data = 0;
    endtask
    task automatic w_cnt(logic [31:0] d);
        cnt_wr = 1; cnt_wdata = d; cyc(); cnt_wr = 0;
    endtask
    task automatic w_ctrl(logic [10:0] d);
        ctrl_wr = 1; ctrl_wdata = d; cyc(); ctrl_wr = 0;
    endtask
    task automatic w_cmp(int ch, logic [31:0] d);
        cmp_wr = 2'b01 << ch; cmp_wdata = d; cyc(); cmp_wr = 0;
    endtask
    task automatic clr(logic [3:0] m);
        flag_clr = m; cyc(); flag_clr = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1;
        model_on = 1;
        // R1: reset state
        chk("R1", "count", count, 0);
        chk("R1", "running", 32'(running), 0);
        chk("R1", "flags", 32'(flags), 0);
        chk("R1", "cap_value", cap_value, 0);
        chk("R1", "cmp_out", 32'(cmp_out), 0);
        chk("R1", "irq", 32'(irq), 0);

        // ch0 high action, ch1 toggle, rising capture, all enabled (R12 layout)
        w_ctrl(11'h0CF);
        w_cmp(0, 5);
        w_cmp(1, 8);
        ien_wr = 1; ien_wdata = 4'hF; cyc(); ien_wr = 0;
        w_cmd(2'b01);
        chk("R2", "running after start", 32'(running), 1);
        tick = 1; cyc(10); tick = 0;
        chk("R2", "count after ten ticks", count, 10);
        chk("R5", "compare flags", 32'(flags), 32'h6);
        chk("R6", "high and toggle pins", 32'(cmp_out), 32'h3);
        chk("R12", "irq with enables", 32'(irq), 1);

        w_cmd(2'b11);
        chk("R2", "stop wins", 32'(running), 0);
        tick = 1; cyc(3); tick = 0;
        chk("R2", "stopped count holds", count, 10);
        clr(4'hF);
        chk("R10", "flags cleared", 32'(flags), 0);
        chk("R11", "irq low", 32'(irq), 0);

        // R3: overflow
        w_cnt(32'hFFFF_FFFE);
        chk("R4", "loaded", count, 32'hFFFF_FFFE);
        w_cmd(2'b01);
        tick = 1; cyc(2); tick = 0;
        chk("R3", "wrapped count", count, 0);
        chk("R3", "overflow flag", 32'(flags), 1);
        clr(4'hF);

        // R4: load with tick, lands on compare 0 value, no event
        tick = 1; cnt_wr = 1; cnt_wdata = 5; cyc(); cnt_wr = 0; tick = 0;
        chk("R4", "load beats tick", count, 5);
        chk("R4", "no event from load", 32'(flags), 0);

        // R7: pulse action on channel 0
        w_ctrl(11'h0D7);
        w_cnt(4);
        tick = 1; cyc(); tick = 0;
        chk("R7", "pulse high", 32'(cmp_out[0]), 1);
        cyc();
        chk("R7", "pulse ends", 32'(cmp_out[0]), 0);

        // R8: follow action on channel 1
        w_ctrl(11'h117);
        w_cnt(7);
        tick = 1; cyc(); tick = 0;
        chk("R8", "follow set", 32'(cmp_out[1]), 1);
        clr(4'h4);
        chk("R8", "follow cleared", 32'(cmp_out[1]), 0);

        // R9: capture edges with the counter stopped
        w_cmd(2'b10);
        w_cnt(100);
        cap_in = 1; cyc(3);
        chk("R9", "rising capture", cap_value, 100);
        chk("R9", "capture flag", 32'(flags[3]), 1);
        w_ctrl(11'h317);
        w_cnt(200);
        cap_in = 0; cyc(3);
        chk("R9", "falling capture", cap_value, 200);
        w_ctrl(11'h517);
        w_cnt(300);
        cap_in = 1; cyc(3);
        chk("R9", "both rising", cap_value, 300);
        w_cnt(301);
        cap_in = 0; cyc(3);
        chk("R9", "both falling", cap_value, 301);
        w_ctrl(11'h717);
        w_cnt(400);
        cap_in = 1; cyc(4);
        chk("R9", "edge none", cap_value, 301);

        // R12/R5: compare 0 disabled via bit 0
        w_ctrl(11'h116);
        clr(4'hF);
        w_cnt(4);
        w_cmd(2'b01);
        tick = 1; cyc(); tick = 0;
        chk("R12", "disabled compare count", count, 5);
        chk("R5", "disabled compare no flag", 32'(flags[1]), 0);

        // Random phase checked against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            tick = r[0];
            cmd_wr = (r[4:1] == 0); cmd_data = r[6:5];
            cnt_wr = (r[10:7] == 0);
            cnt_wdata = r[11] ? (32'hFFFF_FFF8 + 32'(r[14:12])) : 32'(r[15:12]);
            ctrl_wr = (r[19:16] == 0); ctrl_wdata = 11'($urandom);
            cmp_wr = (r[22:20] == 0) ? r[24:23] : 2'b00; cmp_wdata = 32'(r[28:25]);
            ien_wr = (r[31:29] == 0); ien_wdata = 4'($urandom);
            flag_clr = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
            cap_in = ($urandom % 4 == 0) ? ~cap_in : cap_in;
            cyc();
        end
        tick = 0; cmd_wr = 0; cnt_wr = 0; ctrl_wr = 0; cmp_wr = 0; ien_wr = 0; flag_clr = 0;
        cyc(2);
        summary();
        $finish;
    end
endmodule